// File: doc/BRIEF.md
# Resource Admission Checker

The block is the safety filter of a run-time manager that places tasks on a set of reconfigurable tiles. Each of several tasks reports what it occupies right now: a tile-usage mask, a worst-case execution time and a peak power figure. Tasks that are idle or waiting report an all-zero mask, a time of zero and a power of zero. The block merges these per-task reports into global figures: the occupied tile set, the shortest non-zero execution time and the total peak power. It then checks them against the platform rules. The rules are that no tile may be shared, that the tile-enable vector must match exactly the tiles in use, and that the total power must stay within a budget set by the battery level.

The per-task reports arrive as one packed transfer on a valid/ready input. The merged figures and the violation flags leave as one transfer on a valid/ready output. A single register stage sits between the two. The input is ready whenever the output register is empty or is being emptied in the same cycle. An offered result is held unchanged until the consumer takes it. The three power limits and the battery level are plain control inputs. Their values are taken in the same cycle as the task reports.

Top module: `adm_checker`

## Requirements
- R1: `out_tiles` is the bitwise OR of all task tile masks. Task i occupies bits [i*NTILE +: NTILE] of `in_tiles`, and bit k stands for tile k.
- R2: `out_time` is the smallest non-zero value among the task execution times, or 0 when every time is zero. Task i occupies bits [i*TW +: TW] of `in_time`.
- R3: `out_power` is the exact sum of the task peak powers. Task i occupies bits [i*PW +: PW] of `in_power`. The output is PW+log2(NTASK) bits wide, so the sum never wraps.
- R4: `out_conflict` is 1 exactly when the masks of two different tasks share at least one set bit.
- R5: `out_activation` is 1 exactly when `out_tiles` differs from `tile_active` in any bit, whether a used tile is off or an unused tile is on.
- R6: `out_overdraw` is 1 exactly when the power sum is strictly above the limit chosen by `bat_level`. Code 2'b00 selects `thr_low`, 2'b01 selects `thr_mid`, 2'b10 selects `thr_high`, and the undefined code 2'b11 selects `thr_low`.
- R7: `out_any` is the OR of `out_conflict`, `out_activation` and `out_overdraw`.
- R8: An input transfer happens when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The result of a transfer appears with `out_valid` high after the next rising edge. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R9: After reset, `out_valid` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Task reports offered |
| in_ready | output | 1 | Block can take the reports |
| in_tiles | input | NTASK*NTILE | Packed per-task tile masks |
| in_time | input | NTASK*TW | Packed per-task execution times |
| in_power | input | NTASK*PW | Packed per-task peak powers |
| tile_active | input | NTILE | Tile enable vector |
| bat_level | input | 2 | Battery level code |
| thr_low | input | PW+log2(NTASK) | Power limit, low battery |
| thr_mid | input | PW+log2(NTASK) | Power limit, medium battery |
| thr_high | input | PW+log2(NTASK) | Power limit, high battery |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_tiles | output | NTILE | Global tile set |
| out_time | output | TW | Minimum non-zero execution time |
| out_power | output | PW+log2(NTASK) | Total peak power |
| out_conflict | output | 1 | Shared-tile violation |
| out_activation | output | 1 | Tile enable mismatch |
| out_overdraw | output | 1 | Power budget exceeded |
| out_any | output | 1 | OR of the three violations |

## Verification
Every result and flag is due on the rising edge that follows its accepted input transfer, because each passes through exactly one register. The bench changes inputs on falling edges and reads outputs on the falling edge right after the capturing edge, so each check reads exactly that one-cycle result. During a stall it reads the outputs on two successive falling edges and checks that they still equal the first result while `in_ready` is low. It then releases the stall and expects the queued second result one edge later.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic [1:0] {
    BAT_LOW  = 2'b00,
    BAT_MED  = 2'b01,
    BAT_HIGH = 2'b10
  } bat_lvl_e;
endpackage

// File: rtl/adm_tile_merge.sv
module adm_tile_merge #(
  parameter int NTASK = 4,
  parameter int NTILE = 4
) (
  input  logic [NTASK*NTILE-1:0] masks,
  input  logic [NTILE-1:0]       active,
  output logic [NTILE-1:0]       uni,
  output logic                   clash,
  output logic                   mismatch
);
  localparam int NPAIR = NTASK * NTASK;

  logic [NPAIR-1:0] pair_hit;

  // one overlap detector per ordered task pair, upper triangle only
  for (genvar i = 0; i < NTASK; i++) begin : g_row
    for (genvar j = 0; j < NTASK; j++) begin : g_col
      if (j > i) begin : g_live
        assign pair_hit[i*NTASK+j] = |(masks[i*NTILE +: NTILE] & masks[j*NTILE +: NTILE]);
      end else begin : g_dead
        assign pair_hit[i*NTASK+j] = 1'b0;
      end
    end
  end

  always_comb begin
    uni = '0;
    for (int t = 0; t < NTASK; t++) uni = uni | masks[t*NTILE +: NTILE];
  end

  assign clash    = |pair_hit;
  assign mismatch = (uni != active);

  // without a clash the union holds exactly as many tiles as all masks together
  always_comb begin
    int ones;
    ones = 0;
    for (int t = 0; t < NTASK; t++) ones = ones + $countones(masks[t*NTILE +: NTILE]);
    if (!clash) begin
      AST_DISJOINT_COUNT: assert ($countones(uni) == ones); // R4
    end
  end
endmodule

// File: rtl/adm_min_nonzero.sv
module adm_min_nonzero #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   min_o
);
  // key carries an "is zero" flag above the value, so zeros sort last
  logic [W:0] key [N];
  logic [W:0] best;

  for (genvar i = 0; i < N; i++) begin : g_key
    assign key[i] = {(vals[i*W +: W] == '0), vals[i*W +: W]};
  end

  always_comb begin
    best = key[0];
    for (int i = 1; i < N; i++) begin
      if (key[i] < best) best = key[i];
    end
    min_o = best[W] ? '0 : best[W-1:0];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (vals[i*W +: W] != '0) begin
        AST_MIN_BOUND: assert (min_o != '0 && min_o <= vals[i*W +: W]); // R2
      end
    end
  end
endmodule

// File: rtl/adm_power_budget.sv
module adm_power_budget
  import adm_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 12,
  parameter int SW = PW + $clog2(N)
) (
  input  logic [N*PW-1:0] pw,
  input  logic [1:0]      level,
  input  logic [SW-1:0]   lim_low,
  input  logic [SW-1:0]   lim_mid,
  input  logic [SW-1:0]   lim_high,
  output logic [SW-1:0]   total,
  output logic            over
);
  logic [SW-1:0] lim;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + SW'(pw[i*PW +: PW]);
  end

  always_comb begin
    case (bat_lvl_e'(level))
      BAT_MED:  lim = lim_mid;
      BAT_HIGH: lim = lim_high;
      default:  lim = lim_low;
    endcase
  end

  assign over = (total > lim);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      AST_NO_OVERFLOW: assert (total >= SW'(pw[i*PW +: PW])); // R3
    end
  end
endmodule

// File: rtl/adm_checker.sv
module adm_checker #(
  parameter int NTASK = 4,
  parameter int NTILE = 4,
  parameter int TW    = 16,
  parameter int PW    = 12,
  localparam int SW   = PW + $clog2(NTASK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NTASK*NTILE-1:0] in_tiles,
  input  logic [NTASK*TW-1:0]    in_time,
  input  logic [NTASK*PW-1:0]    in_power,
  input  logic [NTILE-1:0]       tile_active,
  input  logic [1:0]             bat_level,
  input  logic [SW-1:0]          thr_low,
  input  logic [SW-1:0]          thr_mid,
  input  logic [SW-1:0]          thr_high,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NTILE-1:0]       out_tiles,
  output logic [TW-1:0]          out_time,
  output logic [SW-1:0]          out_power,
  output logic                   out_conflict,
  output logic                   out_activation,
  output logic                   out_overdraw,
  output logic                   out_any
);
  logic [NTILE-1:0] c_tiles;
  logic [TW-1:0]    c_time;
  logic [SW-1:0]    c_power;
  logic             c_clash, c_mismatch, c_over;
  logic             take;

  adm_tile_merge #(.NTASK(NTASK), .NTILE(NTILE)) u_merge (
    .masks(in_tiles), .active(tile_active),
    .uni(c_tiles), .clash(c_clash), .mismatch(c_mismatch)
  );

  adm_min_nonzero #(.N(NTASK), .W(TW)) u_min (
    .vals(in_time), .min_o(c_time)
  );

  adm_power_budget #(.N(NTASK), .PW(PW), .SW(SW)) u_pwr (
    .pw(in_power), .level(bat_level),
    .lim_low(thr_low), .lim_mid(thr_mid), .lim_high(thr_high),
    .total(c_power), .over(c_over)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_tiles      <= '0;
      out_time       <= '0;
      out_power      <= '0;
      out_conflict   <= 1'b0;
      out_activation <= 1'b0;
      out_overdraw   <= 1'b0;
      out_any        <= 1'b0;
    end else begin
      if (take) begin
        out_valid      <= 1'b1;
        out_tiles      <= c_tiles;
        out_time       <= c_time;
        out_power      <= c_power;
        out_conflict   <= c_clash;
        out_activation <= c_mismatch;
        out_overdraw   <= c_over;
        out_any        <= c_clash | c_mismatch | c_over;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tiles) && $stable(out_time)
      && $stable(out_power) && $stable(out_any)); // R8

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8

  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_any == (out_conflict | out_activation | out_overdraw)); // R7
endmodule

// File: tb/sim_adm_checker.sv
module sim_adm_checker;
  localparam int NT = 4, NL = 4, TW = 16, PW = 12, SW = 14;

  typedef struct packed {
    logic [NL-1:0] tiles;
    logic [TW-1:0] tm;
    logic [SW-1:0] pw;
    logic c, a, o, y;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_ready = 1, out_valid;
  logic [NT*NL-1:0] in_tiles = '0;
  logic [NT*TW-1:0] in_time = '0;
  logic [NT*PW-1:0] in_power = '0;
  logic [NL-1:0] tile_active = '0;
  logic [1:0] bat_level = 0;
  logic [SW-1:0] thr_low = 0, thr_mid = 0, thr_high = 0;
  logic [NL-1:0] out_tiles;
  logic [TW-1:0] out_time;
  logic [SW-1:0] out_power;
  logic out_conflict, out_activation, out_overdraw, out_any;

  logic [NL-1:0] vm [NT];
  logic [TW-1:0] vt [NT];
  logic [PW-1:0] vp [NT];
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adm_checker u0 (.*);

  function automatic exp_t model();
    exp_t e;
    logic [NL-1:0] seen;
    logic [SW-1:0] lim;
    e = '0; seen = '0;
    for (int i = 0; i < NT; i++) begin
      if ((seen & vm[i]) != 0) e.c = 1;
      seen = seen | vm[i];
      if (vt[i] != 0 && (e.tm == 0 || vt[i] < e.tm)) e.tm = vt[i];
      e.pw = e.pw + SW'(vp[i]);
    end
    e.tiles = seen;
    e.a = (seen != tile_active);
    lim = (bat_level == 2'b01) ? thr_mid : (bat_level == 2'b10) ? thr_high : thr_low;
    e.o = e.pw > lim;
    e.y = e.c | e.a | e.o;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load();
    for (int i = 0; i < NT; i++) begin
      in_tiles[i*NL +: NL] = vm[i];
      in_time[i*TW +: TW]  = vt[i];
      in_power[i*PW +: PW] = vp[i];
    end
  endtask

  task automatic check_out(input exp_t e);
    chk("R8 out_valid", out_valid, 1);
    chk("R1 tile union", out_tiles, e.tiles);
    chk("R2 min time", out_time, e.tm);
    chk("R3 power sum", out_power, e.pw);
    chk("R4 conflict", out_conflict, e.c);
    chk("R5 activation", out_activation, e.a);
    chk("R6 overdraw", out_overdraw, e.o);
    chk("R7 summary", out_any, e.y);
  endtask

  task automatic run_one();
    exp_t e;
    @(negedge clk);
    load(); in_valid = 1; out_ready = 1;
    e = model();
    @(negedge clk);
    in_valid = 0;
    check_out(e);
  endtask

  task automatic clear();
    for (int i = 0; i < NT; i++) begin vm[i] = 0; vt[i] = 0; vp[i] = 0; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    exp_t ea, eb;
    void'($urandom(32'd4242));
    clear();
    thr_low = 14'd1000; thr_mid = 14'd5000; thr_high = 14'd12000;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", out_valid, 0);
    chk("R9 reset any", out_any, 0);
    chk("R9 reset power", out_power, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle ready", in_ready, 1);

    // all tasks idle: time 0, no tiles
    clear(); tile_active = 0; bat_level = 0;
    run_one();
    // a single nonzero maximal time
    clear(); vt[2] = 16'hFFFF; run_one();
    // disjoint masks, matching enables, min among mixed
    clear(); vm[0] = 4'b0001; vm[1] = 4'b0100; vm[3] = 4'b1000;
    vt[0] = 30; vt[1] = 7; vt[3] = 9; tile_active = 4'b1101; run_one();
    // overlap between tasks 1 and 3, R4
    vm[3] = 4'b0110; tile_active = 4'b0111; run_one();
    // extra active tile, R5
    clear(); vm[0] = 4'b0010; tile_active = 4'b0011; run_one();
    // used tile left off, R5
    tile_active = 4'b0000; run_one();
    // power at limit then one above, R6 each level
    clear(); tile_active = 0;
    for (int lv = 0; lv < 4; lv++) begin
      bat_level = 2'(lv);
      vp[0] = 12'd800; vp[1] = 12'd200; run_one(); // sum 1000
      vp[1] = 12'd201; run_one();
      vp[0] = 12'hFFF; vp[1] = 12'hFFF; vp[2] = 12'hFFF; vp[3] = 12'hFFF; run_one(); // R3 max 16380
      vp[2] = 0; vp[3] = 0;
    end

    // back-pressure, R8
    clear(); vm[0] = 4'b0011; vt[0] = 5; vp[0] = 12'd900; tile_active = 4'b0011; bat_level = 0;
    @(negedge clk);
    load(); in_valid = 1; out_ready = 0; ea = model();
    @(negedge clk);
    clear(); vm[1] = 4'b1000; vt[1] = 3; vp[1] = 12'd1500;
    load(); eb = model();
    chk("R8 ready low when full", in_ready, 0);
    check_out(ea);
    @(negedge clk);
    chk("R8 stall hold", in_ready, 0);
    check_out(ea);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check_out(eb);
    @(negedge clk);
    chk("R8 drained", out_valid, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NT; i++) begin
        vm[i] = ($urandom % 3 == 0) ? 4'b0 : (4'b1 << ($urandom % 4));
        vt[i] = ($urandom % 3 == 0) ? 16'd0 : 16'($urandom);
        vp[i] = 12'($urandom);
      end
      tile_active = ($urandom % 2) ? 4'($urandom) : (vm[0] | vm[1] | vm[2] | vm[3]);
      bat_level = 2'($urandom);
      thr_low = 14'($urandom); thr_mid = 14'($urandom); thr_high = 14'($urandom);
      run_one();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule